// File: doc/BRIEF.md
# Window Set-Point Corrector

This block turns a requested window centre, given as a converter code, into the code that actually lines up with the converter's measured transfer curve. It multiplies the request by a stored signed gain fraction, adds the rounded product back to the request, subtracts a stored signed offset, and clamps the result to the code range. The correction runs once for each new request and not for every sample. Conversion results taken relative to the corrected centre therefore need no arithmetic of their own.

Software loads the two coefficients through a small write port once calibration is known, and then leaves them alone. The converter controller presents a request with a strobe. While `ready` is low a recomputation is in flight. During that time the controller keeps using the value on `sp_corr`, which holds the previous result until the new one appears. The arithmetic sits in a short pipeline. A parameter sets whether the product gets its own register stage, which makes the latency one or two cycles.

Top module: `spc_setpoint_corr`

## Requirements
- R1: When `ready` rises after an accepted request `s`, `sp_corr` equals `s + round(g*s / 2^15) - o`. Here `g` is the gain register read as a signed two's-complement Q1.15 fraction and `o` is the offset register read as a signed two's-complement integer in LSB. A tie in the rounding goes toward positive infinity.
- R2: A result below 0 is output as 0, and a result above 1023 is output as 1023.
- R3: A write with `coef_we`=1 stores `coef_wdata`. When `coef_sel`=0 all 16 bits go to the gain register. When `coef_sel`=1 only bits 9:0 go to the offset register, and bits 15:10 are ignored. Both registers keep their value until they are written again.
- R4: A strobe is accepted only when `ready` is high and one of two things holds: the value differs from the last accepted request, or a coefficient has been written since that request. Any other strobe leaves `ready` high and leaves `sp_corr` unchanged.
- R5: `ready` is low for exactly 2 cycles after the edge that accepts a request (1 cycle when the product stage is not registered), then it returns high.
- R6: `sp_corr` changes only in the cycle in which `ready` rises. While `ready` is low it shows the previous result.
- R7: A strobe presented while `ready` is low is ignored. It neither starts a computation nor changes the result in flight.
- R8: A coefficient write in the same cycle as an accepted strobe takes effect in that strobe's computation.
- R9: A coefficient write while `ready` is low does not change the result in flight, which keeps the coefficients it had at acceptance. The write does force the next strobe to recompute, even if that strobe has the same value.
- R10: During and right after reset, `ready` is 1, `sp_corr` is 0, and both coefficient registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_valid | input | 1 | Request strobe |
| sp_req | input | 10 | Requested set-point code |
| coef_we | input | 1 | Coefficient write enable |
| coef_sel | input | 1 | Coefficient select: 0 gain, 1 offset |
| coef_wdata | input | 16 | Coefficient write data |
| sp_corr | output | 10 | Corrected set-point code |
| ready | output | 1 | High when no recomputation is pending |

## Verification
Two events can land on the same clock edge: an accepted request and a coefficient write. Both orderings are provoked. In one, a new gain is written on the very edge that accepts a new request, and the result must use the new gain. In the other, an offset is written one cycle after acceptance, and the result in flight must keep the old offset. A repeat of the same request must then recompute with the new offset. Expected codes come from an integer model of the correction formula in the bench, applied to a full sweep of all 1024 requests under four coefficient pairs that reach both clamp limits.

// File: rtl/spc_pkg.sv
package spc_pkg;
   typedef enum logic {
      COEF_GAIN   = 1'b0,
      COEF_OFFSET = 1'b1
   } coef_sel_e;

   // Width needed to hold the signed product of a gain and a zero-extended code
   function automatic int prod_width(input int gain_w, input int sp_w);
      return gain_w + sp_w + 1;
   endfunction
endpackage

// File: rtl/spc_coef_store.sv
module spc_coef_store
   import spc_pkg::*;
#(
   parameter int GAIN_W = 16,
   parameter int OFS_W  = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic                     sel,
   input  logic [GAIN_W-1:0]        wdata,
   output logic signed [GAIN_W-1:0] gain_q,
   output logic signed [OFS_W-1:0]  ofs_q,
   output logic signed [GAIN_W-1:0] gain_fwd,
   output logic signed [OFS_W-1:0]  ofs_fwd
);
   logic wr_gain, wr_ofs;

   assign wr_gain = we && (coef_sel_e'(sel) == COEF_GAIN);
   assign wr_ofs  = we && (coef_sel_e'(sel) == COEF_OFFSET);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_q <= '0;
         ofs_q  <= '0;
      end else begin
         if (wr_gain) gain_q <= wdata;
         if (wr_ofs)  ofs_q  <= wdata[OFS_W-1:0];
      end
   end

   // Forwarded view: a write on the same edge wins over the stored value
   assign gain_fwd = wr_gain ? $signed(wdata) : gain_q;
   assign ofs_fwd  = wr_ofs  ? $signed(wdata[OFS_W-1:0]) : ofs_q;
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl #(
   parameter int SP_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sp_valid,
   input  logic [SP_W-1:0] sp_req,
   input  logic            coef_we,
   input  logic            busy,
   output logic            accept
);
   logic [SP_W-1:0] last_req;
   logic            stale;

   assign accept = sp_valid && !busy && (stale || (sp_req != last_req));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_req <= '0;
         stale    <= 1'b1;
      end else begin
         if (accept) begin
            last_req <= sp_req;
            stale    <= 1'b0;   // a write on this edge is absorbed by the snapshot
         end else if (coef_we) begin
            stale    <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spc_pipe.sv
module spc_pipe
   import spc_pkg::*;
#(
   parameter int SP_W      = 10,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 15,
   parameter int OFS_W     = 10,
   parameter bit PIPE_MUL  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [SP_W-1:0]          sp_in,
   input  logic signed [GAIN_W-1:0] gain_in,
   input  logic signed [OFS_W-1:0]  ofs_in,
   output logic [SP_W-1:0]          sp_corr,
   output logic                     busy
);
   localparam int PROD_W = prod_width(GAIN_W, SP_W);
   localparam int SUM_W  = PROD_W + 2;
   localparam logic signed [SUM_W-1:0] MAX_S = {{(SUM_W-SP_W){1'b0}}, {SP_W{1'b1}}};

   // stage 1: snapshot of request and coefficients
   logic                     s1_v;
   logic [SP_W-1:0]          s1_sp;
   logic signed [GAIN_W-1:0] s1_gain;
   logic signed [OFS_W-1:0]  s1_ofs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_sp   <= '0;
         s1_gain <= '0;
         s1_ofs  <= '0;
      end else begin
         s1_v <= start;
         if (start) begin
            s1_sp   <= sp_in;
            s1_gain <= gain_in;
            s1_ofs  <= ofs_in;
         end
      end
   end

   logic signed [PROD_W-1:0] prod_c;
   assign prod_c = s1_gain * $signed({1'b0, s1_sp});

   // inputs of the final stage
   logic                     m_v;
   logic signed [PROD_W-1:0] m_prod;
   logic [SP_W-1:0]          m_sp;
   logic signed [OFS_W-1:0]  m_ofs;
   logic                     m_pend;

   generate
      if (PIPE_MUL) begin : g_mul_reg
         logic                     s2_v;
         logic signed [PROD_W-1:0] s2_prod;
         logic [SP_W-1:0]          s2_sp;
         logic signed [OFS_W-1:0]  s2_ofs;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s2_v    <= 1'b0;
               s2_prod <= '0;
               s2_sp   <= '0;
               s2_ofs  <= '0;
            end else begin
               s2_v <= s1_v;
               if (s1_v) begin
                  s2_prod <= prod_c;
                  s2_sp   <= s1_sp;
                  s2_ofs  <= s1_ofs;
               end
            end
         end
         assign m_v    = s2_v;
         assign m_prod = s2_prod;
         assign m_sp   = s2_sp;
         assign m_ofs  = s2_ofs;
         assign m_pend = s2_v;
      end else begin : g_mul_comb
         assign m_v    = s1_v;
         assign m_prod = prod_c;
         assign m_sp   = s1_sp;
         assign m_ofs  = s1_ofs;
         assign m_pend = 1'b0;
      end
   endgenerate

   // round half toward +inf, add, subtract offset, clamp
   logic signed [SUM_W-1:0] prod_ext, half_c, delta, sp_ext, ofs_ext, total;
   logic [SP_W-1:0]         clamped;

   assign prod_ext = {{(SUM_W-PROD_W){m_prod[PROD_W-1]}}, m_prod};
   assign half_c   = SUM_W'(1) << (GAIN_FRAC - 1);
   assign delta    = (prod_ext + half_c) >>> GAIN_FRAC;
   assign sp_ext   = {{(SUM_W-SP_W){1'b0}}, m_sp};
   assign ofs_ext  = {{(SUM_W-OFS_W){m_ofs[OFS_W-1]}}, m_ofs};
   assign total    = sp_ext + delta - ofs_ext;

   always_comb begin
      if (total[SUM_W-1])     clamped = '0;
      else if (total > MAX_S) clamped = '1;
      else                    clamped = total[SP_W-1:0];
   end

   logic [SP_W-1:0] out_q;
   always_ff @(posedge clk) begin
      if (!rst_n)   out_q <= '0;
      else if (m_v) out_q <= clamped;
   end

   assign sp_corr = out_q;
   assign busy    = s1_v | m_pend;
endmodule

// File: rtl/spc_setpoint_corr.sv
module spc_setpoint_corr
   import spc_pkg::*;
#(
   parameter int SP_W      = 10,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 15,
   parameter int OFS_W     = 10,
   parameter bit PIPE_MUL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sp_valid,
   input  logic [SP_W-1:0]   sp_req,
   input  logic              coef_we,
   input  logic              coef_sel,
   input  logic [GAIN_W-1:0] coef_wdata,
   output logic [SP_W-1:0]   sp_corr,
   output logic              ready
);
   generate
      if (OFS_W > GAIN_W) begin : g_bad_ofs
         $error("offset field wider than write port");
      end
      if (GAIN_FRAC < 1 || GAIN_FRAC >= GAIN_W) begin : g_bad_frac
         $error("gain fraction bits out of range");
      end
      if (SP_W < 2) begin : g_bad_sp
         $error("set-point width too small");
      end
   endgenerate

   logic signed [GAIN_W-1:0] gain_q, gain_fwd;
   logic signed [OFS_W-1:0]  ofs_q, ofs_fwd;
   logic                     busy_w, accept_w;

   spc_coef_store #(.GAIN_W(GAIN_W), .OFS_W(OFS_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(coef_we), .sel(coef_sel), .wdata(coef_wdata),
      .gain_q(gain_q), .ofs_q(ofs_q), .gain_fwd(gain_fwd), .ofs_fwd(ofs_fwd)
   );

   spc_ctrl #(.SP_W(SP_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .sp_valid(sp_valid), .sp_req(sp_req),
      .coef_we(coef_we), .busy(busy_w), .accept(accept_w)
   );

   spc_pipe #(
      .SP_W(SP_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
      .OFS_W(OFS_W), .PIPE_MUL(PIPE_MUL)
   ) u_pipe (
      .clk(clk), .rst_n(rst_n), .start(accept_w), .sp_in(sp_req),
      .gain_in(gain_fwd), .ofs_in(ofs_fwd), .sp_corr(sp_corr), .busy(busy_w)
   );

   assign ready = !busy_w;
endmodule

// File: rtl/spc_setpoint_corr_chk.sv
module spc_setpoint_corr_chk #(
   parameter int SP_W     = 10,
   parameter bit PIPE_MUL = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ready,
   input logic [SP_W-1:0] sp_corr,
   input logic            accept
);
   // R10: reset state
   p_reset_state_r10: assert property (@(posedge clk)
      !rst_n |=> (ready && sp_corr == '0));

   // R5: ready drops right after an acceptance
   p_drop_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ready);

   // R5: busy window length
   generate
      if (PIPE_MUL) begin : g_len2
         p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> !ready ##1 !ready ##1 ready);
      end else begin : g_len1
         p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> !ready ##1 ready);
      end
   endgenerate

   // R6: the result moves only when ready rises
   p_hold_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sp_corr) |-> $rose(ready));

   // R7: no acceptance while a computation is pending
   p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !accept);
endmodule

bind spc_setpoint_corr spc_setpoint_corr_chk #(.SP_W(SP_W), .PIPE_MUL(PIPE_MUL)) u_chk (
   .clk(clk), .rst_n(rst_n), .ready(ready), .sp_corr(sp_corr), .accept(accept_w)
);

// File: tb/spc_setpoint_corr_tb_top.sv
module spc_setpoint_corr_tb_top;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sp_valid = 1'b0;
   logic [9:0]  sp_req = '0;
   logic        coef_we = 1'b0;
   logic        coef_sel = 1'b0;
   logic [15:0] coef_wdata = '0;
   logic [9:0]  sp_corr;
   logic        ready;

   int nchk = 0;
   int nbad = 0;
   bit done = 1'b0;
   int cur_g = 0;
   int cur_o = 0;

   always #2 clk = ~clk;

   spc_setpoint_corr dut_i (
      .clk(clk), .rst_n(rst_n), .sp_valid(sp_valid), .sp_req(sp_req),
      .coef_we(coef_we), .coef_sel(coef_sel), .coef_wdata(coef_wdata),
      .sp_corr(sp_corr), .ready(ready)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint raw_model(input int sp, input int g, input int o);
      longint p;
      p = longint'(g) * sp + 16384;
      return sp + (p >>> 15) - o;
   endfunction

   function automatic int model(input int sp, input int g, input int o);
      longint t;
      t = raw_model(sp, g, o);
      if (t < 0) return 0;
      if (t > 1023) return 1023;
      return int'(t);
   endfunction

   task automatic wr_coef(input bit sel, input logic [15:0] d);
      @(negedge clk);
      coef_we = 1'b1; coef_sel = sel; coef_wdata = d;
      @(negedge clk);
      coef_we = 1'b0;
      if (sel) cur_o = int'($signed(d[9:0]));
      else     cur_g = int'($signed(d));
   endtask

   // Present a request; on return we are one half cycle after the accepting edge.
   task automatic strobe(input int sp);
      @(negedge clk);
      sp_valid = 1'b1; sp_req = 10'(sp);
      @(negedge clk);
      sp_valid = 1'b0;
   endtask

   // Full request, checking busy window and result.
   task automatic run_req(input int sp, input int exp, input string tag);
      int prev;
      prev = int'(sp_corr);
      strobe(sp);
      check(ready == 1'b0, "R5 ready low after accept", int'(ready), 0);
      for (int i = 1; i < LAT; i++) begin
         @(negedge clk);
         check(ready == 1'b0, "R5 ready still low", int'(ready), 0);
         check(int'(sp_corr) == prev, "R6 hold while busy", int'(sp_corr), prev);
      end
      @(negedge clk);
      check(ready == 1'b1, "R5 ready back", int'(ready), 1);
      check(int'(sp_corr) == exp, tag, int'(sp_corr), exp);
   endtask

   task automatic report;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nbad++;
         $display("FAIL R5 watchdog actual=hung expected=done");
         report();
      end
   end

   initial begin
      int e, hold;
      repeat (4) @(negedge clk);
      // R10: reset values
      check(ready == 1'b1, "R10 ready in reset", int'(ready), 1);
      check(sp_corr == 10'd0, "R10 sp_corr in reset", int'(sp_corr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1'b1, "R10 ready after reset", int'(ready), 1);
      // R10/R3: coefficients reset to zero -> identity
      run_req(123, 123, "R10 zero coefficients");

      // R1/R2 sweeps under four coefficient pairs
      for (int k = 0; k < 4; k++) begin
         logic [15:0] g, o;
         case (k)
            0: begin g = 16'h0CCD; o = 16'd5;      end
            1: begin g = 16'hE000; o = 16'hFFF9;   end  // -0.25, -7
            2: begin g = 16'h7FFF; o = 16'd40;     end  // high clamp
            default: begin g = 16'hC000; o = 16'd300; end // -0.5, low clamp
         endcase
         wr_coef(1'b0, g);
         wr_coef(1'b1, o);
         for (int s = 0; s < 1024; s++) begin
            longint r;
            r = raw_model(s, cur_g, cur_o);
            run_req(s, model(s, cur_g, cur_o),
                    (r < 0 || r > 1023) ? "R2 clamp" : "R1 correction");
         end
      end

      // R4: same value again is ignored
      hold = int'(sp_corr);
      strobe(1023);
      check(ready == 1'b1, "R4 repeat keeps ready", int'(ready), 1);
      @(negedge clk);
      check(int'(sp_corr) == hold, "R4 repeat keeps result", int'(sp_corr), hold);

      // R3: offset uses only bits 9:0; gain written back to zero
      wr_coef(1'b0, 16'h0000);
      wr_coef(1'b1, 16'hFC05);
      check(cur_o == 5, "R3 bench offset decode", cur_o, 5);
      run_req(500, 495, "R3 offset low bits only");

      // R7: strobe while busy ignored
      e = model(200, cur_g, cur_o);
      strobe(200);
      sp_valid = 1'b1; sp_req = 10'd700;
      @(negedge clk);
      sp_valid = 1'b0;
      check(int'(sp_corr) == 495, "R7 hold during busy", int'(sp_corr), 495);
      @(negedge clk);
      check(int'(sp_corr) == e, "R7 busy strobe ignored", int'(sp_corr), e);
      @(negedge clk);
      check(ready == 1'b1 && int'(sp_corr) == e, "R7 no late start", int'(sp_corr), e);

      // R8: gain write on the accepting edge applies to that request
      @(negedge clk);
      sp_valid = 1'b1; sp_req = 10'd600;
      coef_we = 1'b1; coef_sel = 1'b0; coef_wdata = 16'h2000;  // +0.25
      @(negedge clk);
      sp_valid = 1'b0; coef_we = 1'b0; cur_g = 16'h2000;
      check(ready == 1'b0, "R8 accepted", int'(ready), 0);
      repeat (LAT) @(negedge clk);
      e = model(600, cur_g, cur_o);
      check(int'(sp_corr) == e, "R8 same-edge write used", int'(sp_corr), e);

      // R9: write while busy; in-flight uses old, repeat recomputes
      e = model(300, cur_g, cur_o);
      strobe(300);
      coef_we = 1'b1; coef_sel = 1'b1; coef_wdata = 16'hFFE0;  // -32
      @(negedge clk);
      coef_we = 1'b0; cur_o = -32;
      @(negedge clk);
      check(int'(sp_corr) == e, "R9 in-flight keeps old offset", int'(sp_corr), e);
      run_req(300, model(300, cur_g, cur_o), "R9 repeat after write recomputes");

      done = 1'b1;
      report();
   end
endmodule